// File: doc/BRIEF.md
# Tile 5/3 Wavelet Analysis Engine

This block performs one level of a separable two-dimensional 5/3 forward wavelet analysis on a fixed 8x8 tile of signed integer samples. Samples enter one per accepted beat in raster order (row 0 first, column 0 first within a row) over a valid/ready input. Every completed row is filtered horizontally at once with shift-and-add arithmetic. The eight row results go into an on-chip 8x8 transpose store: the smooth half in columns 0 to 3 and the detail half in columns 4 to 7.

When the 64th sample has been taken, input ready drops and the block runs a vertical pass. It produces one final coefficient per cycle, 64 in all, grouped into four 4x4 subbands. Each coefficient carries a 2-bit subband tag, a row coordinate, a column coordinate, and an end marker on the very last one. The output has no back-pressure. A consumer must take one coefficient per cycle while the output is valid.

Top module: `dwt2d53_tile`

## Requirements
- R1: While reset is asserted and on the first cycle after release, outValid and outEof are 0 and inReady is 1.
- R2: The horizontal smooth coefficient k (k = 0..3) of a row x is floor((-x[2k-2] + 2x[2k-1] + 6x[2k] + 2x[2k+1] - x[2k+2]) / 8). The division is an arithmetic right shift by 3.
- R3: The horizontal detail coefficient k of a row x is floor((-x[2k] + 2x[2k+1] - x[2k+2]) / 2). The division is an arithmetic right shift by 1.
- R4: The vertical pass applies the same two formulas down each column of the row results. Subband tag 0 (LL) is horizontal smooth then vertical smooth. Tag 1 (HL) is horizontal detail then vertical smooth. Tag 2 (LH) is horizontal smooth then vertical detail. Tag 3 (HH) is horizontal detail then vertical detail. outRow is the vertical index k and outCol is the horizontal index k.
- R5: Any sample index outside 0..7, in either pass, contributes the value 0.
- R6: inReady goes low after the 64th sample of a tile is accepted. It stays low while coefficients are emitted. It returns high in the cycle that presents the final coefficient.
- R7: The 64 coefficients appear on consecutive cycles. The first is LL at row 0, column 0. They come in tag order 0, 1, 2, 3, and within a tag in raster order (column index fastest).
- R8: outEof is 1 only with the final coefficient (tag 3, row 3, column 3). outValid is 0 on the cycle after it.
- R9: An accepted sample with inSof set is taken as sample 0 of a new tile, whatever was accepted before it.
- R10: With DATA_W-bit signed inputs, the row results are held in DATA_W+4 bits and the outputs in DATA_W+8 bits. Full-scale inputs give exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample present |
| inData | input | DATA_W | Signed input sample |
| inSof | input | 1 | Marks the sample as the first of a tile |
| inReady | output | 1 | Block accepts a sample this cycle |
| outValid | output | 1 | Output coefficient present |
| outData | output | DATA_W+8 | Signed output coefficient |
| outBand | output | 2 | Subband tag (0 LL, 1 HL, 2 LH, 3 HH) |
| outRow | output | 2 | Row coordinate inside the subband |
| outCol | output | 2 | Column coordinate inside the subband |
| outEof | output | 1 | Final coefficient of the tile |

## Verification
The first pattern is a linear ramp. Its detail bands stay near zero away from the borders, so edge extension errors stand out. The second is a single impulse at the tile corner, which exposes the zero handling and any wrong tap weights. The third is a full-scale checkerboard, which drives the detail bands to their largest magnitude and shows truncation. A pseudo-random tile fed with idle gaps tests stall handling, and a burst of partial samples before a start-flagged tile tests the restart.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

  typedef struct packed {
    logic       pixTake;
    logic [2:0] pixCol;
    logic       rowWrite;
    logic [2:0] rowSel;
    logic       emit;
    logic [1:0] band;
    logic [1:0] r;
    logic [1:0] c;
    logic       last;
  } dwtStrobe_t;

  // smooth tap: (-a + 2b + 6c + 2d - e) >>> 3, shifts and adds only
  function automatic int lowTap(input int a, input int b, input int c,
                                input int d, input int e);
    int acc;
    acc = (b <<< 1) + (c <<< 2) + (c <<< 1) + (d <<< 1) - a - e;
    return acc >>> 3;
  endfunction

  // detail tap: (-a + 2b - c) >>> 1
  function automatic int highTap(input int a, input int b, input int c);
    int acc;
    acc = (b <<< 1) - a - c;
    return acc >>> 1;
  endfunction

endpackage

// File: rtl/dwt2d53_ctrl.sv
module dwt2d53_ctrl
  import dwt53_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inSof,
  output logic       inReady,
  output dwtStrobe_t strobe
);
  localparam int TILE_N = 64;
  localparam logic [5:0] LAST_IDX = 6'(TILE_N - 1);

  typedef enum logic {ST_ROWS, ST_COLS} phase_t;
  phase_t     state;
  logic [5:0] pixCnt;
  logic [5:0] outCnt;
  logic [5:0] effIdx;
  logic       take;

  assign inReady = (state == ST_ROWS);
  assign effIdx  = inSof ? 6'd0 : pixCnt;
  assign take    = (state == ST_ROWS) && inValid;

  always_comb begin
    strobe          = '0;
    strobe.pixTake  = take;
    strobe.pixCol   = effIdx[2:0];
    strobe.rowWrite = take && (effIdx[2:0] == 3'd7);
    strobe.rowSel   = effIdx[5:3];
    strobe.emit     = (state == ST_COLS);
    strobe.band     = outCnt[5:4];
    strobe.r        = outCnt[3:2];
    strobe.c        = outCnt[1:0];
    strobe.last     = (state == ST_COLS) && (outCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_ROWS;
      pixCnt <= '0;
      outCnt <= '0;
    end else begin
      case (state)
        ST_ROWS: if (take) begin
          if (effIdx == LAST_IDX) begin
            state  <= ST_COLS;
            pixCnt <= '0;
            outCnt <= '0;
          end else begin
            pixCnt <= effIdx + 6'd1;
          end
        end
        default: begin
          outCnt <= outCnt + 6'd1;
          if (outCnt == LAST_IDX) state <= ST_ROWS;
        end
      endcase
    end
  end
endmodule

// File: rtl/dwt2d53_datapath.sv
module dwt2d53_datapath
  import dwt53_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = DATA_W + 4,
  parameter int OUT_W  = DATA_W + 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [DATA_W-1:0] inData,
  input  dwtStrobe_t              strobe,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData,
  output logic [1:0]              outBand,
  output logic [1:0]              outRow,
  output logic [1:0]              outCol,
  output logic                    outEof
);
  localparam int SIDE = 8;
  localparam int HALF = SIDE / 2;
  localparam int EXT  = SIDE + 4;

  logic signed [DATA_W-1:0] pixReg  [0:SIDE-1];
  logic signed [DATA_W-1:0] rowExt  [0:EXT-1];
  logic signed [ROW_W-1:0]  rowCoef [0:SIDE-1];
  logic signed [ROW_W-1:0]  tbuf    [0:SIDE-1][0:SIDE-1];
  logic signed [ROW_W-1:0]  colExt  [0:EXT-1];
  logic [2:0]               colSel;
  int                       lowV, highV, base;
  logic signed [OUT_W-1:0]  colResult;

  // partial row capture
  always_ff @(posedge clk) begin
    if (strobe.pixTake) pixReg[strobe.pixCol] <= inData;
  end

  // zero-extended row: two zero guards on each side
  assign rowExt[0]       = '0;
  assign rowExt[1]       = '0;
  assign rowExt[EXT-2]   = '0;
  assign rowExt[EXT-1]   = '0;
  assign rowExt[SIDE+1]  = inData;
  for (genvar j = 0; j < SIDE - 1; j++) begin : g_rowExt
    assign rowExt[j+2] = pixReg[j];
  end

  for (genvar k = 0; k < HALF; k++) begin : g_rowFilt
    assign rowCoef[k] = ROW_W'(lowTap(int'(rowExt[2*k]), int'(rowExt[2*k+1]),
                                      int'(rowExt[2*k+2]), int'(rowExt[2*k+3]),
                                      int'(rowExt[2*k+4])));
    assign rowCoef[k+HALF] = ROW_W'(highTap(int'(rowExt[2*k+2]), int'(rowExt[2*k+3]),
                                            int'(rowExt[2*k+4])));
  end

  // transpose store, one full row per write
  always_ff @(posedge clk) begin
    if (strobe.rowWrite) begin
      for (int j = 0; j < SIDE; j++) tbuf[strobe.rowSel][j] <= rowCoef[j];
    end
  end

  // column fetch: detail half of the store for tags with horizontal detail
  assign colSel = {strobe.band[0], strobe.c};
  assign colExt[0]     = '0;
  assign colExt[1]     = '0;
  assign colExt[EXT-2] = '0;
  assign colExt[EXT-1] = '0;
  for (genvar i = 0; i < SIDE; i++) begin : g_colExt
    assign colExt[i+2] = tbuf[i][colSel];
  end

  always_comb begin
    base  = {29'd0, strobe.r, 1'b0};
    lowV  = lowTap(int'(colExt[base]), int'(colExt[base+1]), int'(colExt[base+2]),
                   int'(colExt[base+3]), int'(colExt[base+4]));
    highV = highTap(int'(colExt[base+2]), int'(colExt[base+3]), int'(colExt[base+4]));
    colResult = strobe.band[1] ? OUT_W'(highV) : OUT_W'(lowV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outEof   <= 1'b0;
      outData  <= '0;
      outBand  <= '0;
      outRow   <= '0;
      outCol   <= '0;
    end else begin
      outValid <= strobe.emit;
      outEof   <= strobe.last;
      if (strobe.emit) begin
        outData <= colResult;
        outBand <= strobe.band;
        outRow  <= strobe.r;
        outCol  <= strobe.c;
      end
    end
  end
endmodule

// File: rtl/dwt2d53_tile.sv
module dwt2d53_tile
  import dwt53_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       inData,
  input  logic                    inSof,
  output logic                    inReady,
  output logic                    outValid,
  output logic [DATA_W+7:0]       outData,
  output logic [1:0]              outBand,
  output logic [1:0]              outRow,
  output logic [1:0]              outCol,
  output logic                    outEof
);
  localparam int ROW_W = DATA_W + 4;
  localparam int OUT_W = DATA_W + 8;

  dwtStrobe_t strobe;

  dwt2d53_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof),
    .inReady(inReady), .strobe(strobe)
  );

  dwt2d53_datapath #(.DATA_W(DATA_W), .ROW_W(ROW_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .inData(inData), .strobe(strobe),
    .outValid(outValid), .outData(outData), .outBand(outBand),
    .outRow(outRow), .outCol(outCol), .outEof(outEof)
  );
endmodule

// File: rtl/dwt2d53_checker.sv
module dwt2d53_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       inReady,
  input logic       outValid,
  input logic [1:0] outBand,
  input logic [1:0] outRow,
  input logic [1:0] outCol,
  input logic       outEof
);
  a_r6_ready_low_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outEof) |-> !inReady);

  a_r8_eof_last: assert property (@(posedge clk) disable iff (!rst_n)
    outEof |-> (outValid && outBand == 2'd3 && outRow == 2'd3 && outCol == 2'd3));

  a_r8_eof_ends: assert property (@(posedge clk) disable iff (!rst_n)
    outEof |=> !outValid);

  a_r7_first_ll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> (outBand == 2'd0 && outRow == 2'd0 && outCol == 2'd0));

  a_r7_order_step: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outEof) |=>
      (outValid && {outBand, outRow, outCol} == $past({outBand, outRow, outCol}) + 6'd1));
endmodule

bind dwt2d53_tile dwt2d53_checker u_chk (
  .clk(clk), .rst_n(rst_n), .inReady(inReady), .outValid(outValid),
  .outBand(outBand), .outRow(outRow), .outCol(outCol), .outEof(outEof)
);

// File: tb/tb_dwt2d53_tile.sv
module tb_dwt2d53_tile;
  localparam int DATA_W = 8;
  localparam int OUT_W  = DATA_W + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inSof = 1'b0;
  logic inReady, outValid, outEof;
  logic [OUT_W-1:0] outData;
  logic [1:0] outBand, outRow, outCol;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int img [64];
  int expData [$];
  int expTag [$];
  logic prevValid = 1'b0;
  logic prevEof = 1'b0;

  always #4 clk = ~clk;

  dwt2d53_tile #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outBand(outBand),
    .outRow(outRow), .outCol(outCol), .outEof(outEof)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  function automatic int pix(input int r, input int c);
    if (r < 0 || r > 7 || c < 0 || c > 7) return 0;  // R5
    return img[r*8 + c];
  endfunction

  function automatic int lp(input int a, input int b, input int c, input int d, input int e);
    return (-a + 2*b + 6*c + 2*d - e) >>> 3;  // R2
  endfunction

  function automatic int hp(input int a, input int b, input int c);
    return (-a + 2*b - c) >>> 1;  // R3
  endfunction

  // behavioural reference: fills the expectation queues for the tile in img
  task automatic pushExpected();
    int mid [8][8];
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 4; k++) begin
        mid[r][k]   = lp(pix(r,2*k-2), pix(r,2*k-1), pix(r,2*k), pix(r,2*k+1), pix(r,2*k+2));
        mid[r][k+4] = hp(pix(r,2*k), pix(r,2*k+1), pix(r,2*k+2));
      end
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          int col, v;
          int t [12];
          col = c + ((b % 2) * 4);
          for (int i = 0; i < 12; i++) t[i] = (i >= 2 && i < 10) ? mid[i-2][col] : 0;
          if (b >= 2) v = hp(t[2*r+2], t[2*r+3], t[2*r+4]);                    // R4
          else        v = lp(t[2*r], t[2*r+1], t[2*r+2], t[2*r+3], t[2*r+4]);  // R4
          expData.push_back(v);
          expTag.push_back(b*16 + r*4 + c);
        end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid) begin
        if (expData.size() == 0) begin
          check(1'b0, "R7 unexpected output", 1, 0);
        end else begin
          int ed, et;
          ed = expData.pop_front();
          et = expTag.pop_front();
          check($signed(outData) == ed, "R4 coefficient value", $signed(outData), ed);
          check({outBand, outRow, outCol} == 6'(et), "R7 tag/coordinate",
                int'({outBand, outRow, outCol}), et);
          check(outEof == (et == 63), "R8 end marker", int'(outEof), int'(et == 63));
          check(inReady == outEof, "R6 ready during drain", int'(inReady), int'(outEof));
        end
      end else if (prevValid && !prevEof) begin
        check(1'b0, "R7 gap in output burst", 0, 1);
      end
      if (prevEof) check(!outValid, "R8 idle after end", int'(outValid), 0);
      prevValid <= outValid;
      prevEof   <= outEof;
    end
  end

  task automatic sendPix(input int v, input bit sof);
    @(negedge clk);
    inValid = 1'b1;
    inData  = DATA_W'(v);
    inSof   = sof;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inSof   = 1'b0;
  endtask

  task automatic runTile(input int gaps);
    pushExpected();
    for (int i = 0; i < 64; i++) begin
      sendPix(img[i], i == 0);
      for (int g = 0; g < gaps; g++) @(negedge clk);
    end
    @(negedge clk);
    check(inReady == 1'b0, "R6 ready low after last sample", int'(inReady), 0);
    while (expData.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(inReady == 1'b1, "R6 ready back after drain", int'(inReady), 1);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R1 reset inReady", int'(inReady), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outEof == 1'b0, "R1 after release", int'(outValid), 0);
    check(inReady == 1'b1, "R1 ready after release", int'(inReady), 1);

    // ramp: R2 R3 R5 edges
    for (int i = 0; i < 64; i++) img[i] = (i % 8) * 11 + (i / 8) * 5 - 60;
    runTile(0);

    // corner impulse: R5 zero extension
    for (int i = 0; i < 64; i++) img[i] = 0;
    img[0] = 100;
    img[63] = -77;
    runTile(0);

    // full-scale checkerboard: R10 growth
    for (int i = 0; i < 64; i++) img[i] = (((i % 8) + (i / 8)) % 2 == 1) ? 127 : -128;
    runTile(0);

    // full-scale vertical stripes: R10
    for (int i = 0; i < 64; i++) img[i] = ((i % 8) % 2 == 1) ? -128 : 127;
    runTile(0);

    // pseudo-random with stalls
    seed = 12345;
    for (int i = 0; i < 64; i++) begin
      seed = seed * 1103515245 + 12345;
      img[i] = ((seed >>> 16) & 255) - 128;
    end
    runTile(2);

    // R9: stray samples, then a start-flagged tile restarts counting
    for (int i = 0; i < 11; i++) sendPix(i * 9 - 40, 1'b0);
    for (int i = 0; i < 64; i++) img[i] = 50 - ((i * 37) % 101);
    runTile(0);

    check(expData.size() == 0, "R7 all coefficients seen", expData.size(), 0);
    finishRun();
  end
endmodule